// File: doc/BRIEF.md
# Glitch-Filtering Timestamp Sampler

This block sits between a free-running 64-bit time counter, whose value can briefly jump forward or backward by a power of two, and a consumer that needs a trustworthy timestamp. The consumer raises a request. Once the block accepts it, the block latches one raw counter value on every clock and keeps the three most recent values in a small window. It hands back the middle value only when the oldest value is below it and the newest value is above it. Because the comparison is strict, the three values are also distinct.

The reader is faster than the counter, so the counter can show the same value on back-to-back clocks. A jump can also go either way, so a pair of samples is never enough to tell a good value from a bad one. When a window fails the check, the block drops the oldest value, latches one fresh value and judges again. The number of judgments is limited by a parameter. When the limit is reached, the block still completes the request, returns the middle of the last window and flags an error.

Top module: `stamp_validator`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a clock edge, the block drops any request in progress. After that edge `rdy` is 1, `vld` is 0, `err` is 0 and `stamp` is 0.
- R2: A request is accepted at a clock edge where `req` and `rdy` are both 1. The first sample is `cnt_raw` at that edge. One further sample is taken at each following edge until a result is produced.
- R3: Take three consecutive samples a, b, c. If a < b < c, the block returns b on `stamp` with `vld` = 1 and `err` = 0.
- R4: In the best case, `vld` rises after the third edge that follows the accepting edge, and the result is the sample taken one edge after acceptance.
- R5: Two equal samples anywhere in a window make that window fail.
- R6: A window with a backward or forward jump fails. Each failure moves the window by exactly one sample, so window k covers samples k, k+1 and k+2 and is judged at edge 3+k after acceptance.
- R7: Comparisons are unsigned over all 64 bits. Values with bit 63 set rank above values with bit 63 clear. A window that spans the counter wrapping from all ones to zero fails.
- R8: If `RETRY_MAX` windows (default 16) fail in a row, then at edge `RETRY_MAX`+2 after acceptance the block sets `vld` = 1 and `err` = 1, and `stamp` holds the middle sample of the last window judged.
- R9: `rdy` is 0 from the accepting edge until `vld` is shown. `req` held high during that time does not start a second operation. `rdy` is 1 again in the same cycle as `vld`.
- R10: `vld` and `err` each last exactly one cycle, and `err` is never 1 unless `vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_raw | input | 64 | Raw counter value, possibly glitched |
| req | input | 1 | Timestamp request |
| rdy | output | 1 | Idle; a request can be accepted |
| vld | output | 1 | One-cycle result strobe |
| stamp | output | 64 | Returned timestamp, valid with `vld` |
| err | output | 1 | With `vld`: retry limit reached, result not verified |

## Verification
The embedded properties check on every cycle that `err` only appears together with `vld`, that `vld` is a single-cycle pulse, and that `rdy` falls after an acceptance. They also check that every clean result lies strictly between the outer samples of its window, that the retry count stays below its limit, and that each shift brings in the current counter value. Some behaviour can only be shown by the directed scenarios, because each needs a specific sample sequence at a known edge. These are the exact latency for each window position, the rejection of repeated values, of backward and forward jumps and of wraparound, the unsigned ranking across bit 63, the give-up result after the retry limit, and the abort on a reset part-way through a request.

// File: rtl/svld_pkg.sv
// Package: shared constants and types for the timestamp validator.
// Assumes: the window is always three samples deep (a rule of the function, not a tuning knob).
package svld_pkg;

    localparam int WIN_LEN = 3;
    localparam int MID_IDX = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_JUDGE = 2'd2
    } vstate_e;

endpackage

// File: rtl/svld_window.sv
// Module: sample window, a shift register of WIN_LEN counter samples.
// Index 0 is the oldest sample and index WIN_LEN-1 the newest.
// Assumes: shift is asserted only in cycles where a new sample is wanted.
module svld_window #(
    parameter int W       = 64,
    parameter int WIN_LEN = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift,
    input  logic [W-1:0]                  din,
    output logic [WIN_LEN-1:0][W-1:0]     taps
);

    localparam int NEWEST = WIN_LEN - 1;

    for (genvar g = 0; g < WIN_LEN; g++) begin : g_stage
        // Each stage takes the next newer stage; the newest stage takes the raw input.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                taps[g] <= '0;
            end else if (shift) begin
                if (g == NEWEST) begin
                    taps[g] <= din;
                end else begin
                    taps[g] <= taps[(g == NEWEST) ? g : g + 1];
                end
            end
        end
    end

    // R2
    shift_takes_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (taps[NEWEST] == $past(din)));

endmodule

// File: rtl/svld_judge.sv
// Module: window judge. Reports ok when every sample is strictly below its newer neighbour.
// Strict ordering also makes all samples distinct. The comparison is unsigned on the full width.
// Assumes: taps come from svld_window, with index 0 the oldest.
module svld_judge #(
    parameter int W       = 64,
    parameter int WIN_LEN = 3
) (
    input  logic [WIN_LEN-1:0][W-1:0] taps,
    output logic                      ok
);

    localparam int PAIRS = WIN_LEN - 1;

    logic [PAIRS-1:0] rising;

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        // Compare one adjacent pair of samples.
        always_comb rising[g] = (taps[g] < taps[g+1]);
    end

    // The window passes only if every adjacent pair rises.
    always_comb ok = &rising;

endmodule

// File: rtl/svld_retry.sv
// Module: retry counter. Counts failed judgments of the current request.
// last is high while the next failure would be the final allowed one.
// Assumes: clr and inc are never asserted in the same cycle.
module svld_retry #(
    parameter int MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = (MAX < 2) ? 1 : $clog2(MAX + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX - 1);

    logic [CW-1:0] cnt_q;

    // Clear on a new request; advance on each non-final failure.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final allowed judgment.
    always_comb last = (cnt_q == LAST_VAL);

    // R8
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAX));

endmodule

// File: rtl/stamp_validator.sv
// Module: top of the glitch-filtering timestamp sampler.
// On an accepted request it fills a three-sample window, then judges it once per cycle,
// sliding by one fresh sample after each failure, up to RETRY_MAX judgments.
// Assumes: cnt_raw is already synchronous to clk; RETRY_MAX >= 1.
module stamp_validator #(
    parameter int CNT_W     = 64,
    parameter int RETRY_MAX = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_raw,
    input  logic             req,
    output logic             rdy,
    output logic             vld,
    output logic [CNT_W-1:0] stamp,
    output logic             err
);

    import svld_pkg::*;

    localparam logic [1:0] FILL_DONE = 2'(WIN_LEN - 1);

    vstate_e                         state_q;
    logic [1:0]                      fill_q;
    logic [WIN_LEN-1:0][CNT_W-1:0]   taps;
    logic                            win_ok;
    logic                            ret_last;
    logic                            accept;
    logic                            judging;
    logic                            slide;
    logic                            win_shift;

    // Derive the handshake and datapath controls from the state.
    always_comb begin
        rdy       = (state_q == ST_IDLE);
        accept    = req && rdy;
        judging   = (state_q == ST_JUDGE);
        slide     = judging && !win_ok && !ret_last;
        win_shift = accept || (state_q == ST_FILL) || slide;
    end

    svld_window #(.W(CNT_W), .WIN_LEN(WIN_LEN)) i_window (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (win_shift),
        .din   (cnt_raw),
        .taps  (taps)
    );

    svld_judge #(.W(CNT_W), .WIN_LEN(WIN_LEN)) i_judge (
        .taps (taps),
        .ok   (win_ok)
    );

    svld_retry #(.MAX(RETRY_MAX)) i_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (slide),
        .last  (ret_last)
    );

    // Sequence idle, fill and judge, and register the result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fill_q  <= '0;
            vld     <= 1'b0;
            err     <= 1'b0;
            stamp   <= '0;
        end else begin
            vld <= 1'b0;
            err <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        fill_q  <= 2'd1;
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    fill_q <= fill_q + 2'd1;
                    if (fill_q == FILL_DONE) begin
                        state_q <= ST_JUDGE;
                    end
                end
                ST_JUDGE: begin
                    if (win_ok || ret_last) begin
                        vld     <= 1'b1;
                        err     <= !win_ok;
                        stamp   <= taps[MID_IDX];
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    err_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> vld);

    // R10
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && rdy) |=> !rdy);

    // R3
    stamp_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !err) |-> ((stamp > $past(taps[0])) && (stamp < $past(taps[WIN_LEN-1]))));

endmodule

// File: tb/test_stamp_validator.sv
module test_stamp_validator;

    localparam int RMAX = 16;
    localparam int PLEN = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt_raw = '0;
    logic        req = 1'b0;
    logic        rdy;
    logic        vld;
    logic [63:0] stamp;
    logic        err;

    int errs = 0;
    int checks = 0;
    logic [63:0] pat [PLEN];

    always #5 clk = ~clk;

    stamp_validator #(.CNT_W(64), .RETRY_MAX(RMAX)) i_stamp_validator (
        .clk(clk), .rst_n(rst_n), .cnt_raw(cnt_raw), .req(req),
        .rdy(rdy), .vld(vld), .stamp(stamp), .err(err)
    );

    task automatic check(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected outcome from the requirements: first rising window, else give-up on the last one.
    function automatic void ref_model(output int j, output bit e, output logic [63:0] s);
        j = RMAX - 1; e = 1'b1; s = pat[RMAX];
        for (int k = 0; k < RMAX; k++) begin
            if (pat[k] < pat[k+1] && pat[k+1] < pat[k+2]) begin
                j = k; e = 1'b0; s = pat[k+1];
                break;
            end
        end
    endfunction

    // Drive pat[] one sample per edge from acceptance and check the whole response.
    task automatic run_case(input string tag, input bit hold_req);
        int j_exp; bit e_exp; logic [63:0] s_exp;
        int n; bit busy_bad; bit seen;
        ref_model(j_exp, e_exp, s_exp);
        @(negedge clk);
        check(rdy == 1'b1, {tag, " R9 rdy before request"}, 64'(rdy), 64'd1);
        req = 1'b1; cnt_raw = pat[0];
        @(posedge clk);
        n = 0; busy_bad = 0; seen = 0;
        while (n <= 40) begin
            @(negedge clk);
            if (vld) begin
                req = 1'b0; seen = 1;
                break;
            end
            if (rdy) busy_bad = 1;
            req = hold_req;
            cnt_raw = pat[(n + 1 < PLEN) ? n + 1 : PLEN - 1];
            @(posedge clk);
            n++;
        end
        check(seen, {tag, " R2 result arrives"}, 64'(seen), 64'd1);
        check(n == 3 + j_exp, {tag, " R4/R6 latency in edges"}, 64'(n), 64'(3 + j_exp));
        check(stamp == s_exp, {tag, " R3 stamp value"}, stamp, s_exp);
        check(err == e_exp, {tag, " R8 err flag"}, 64'(err), 64'(e_exp));
        check(!busy_bad, {tag, " R9 rdy low while busy"}, 64'(busy_bad), 64'd0);
        check(rdy == 1'b1, {tag, " R9 rdy with vld"}, 64'(rdy), 64'd1);
        @(negedge clk);
        check(vld == 1'b0 && err == 1'b0, {tag, " R10 single-cycle strobe"}, 64'({vld, err}), 64'd0);
        check(rdy == 1'b1, {tag, " R9 no second accept"}, 64'(rdy), 64'd1);
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(rdy == 1'b1 && vld == 1'b0 && err == 1'b0 && stamp == '0, "R1 reset state",
              64'({rdy, vld, err}), 64'b100);
        rst_n = 1'b1;
    endtask

    task automatic t_clean;
        for (int k = 0; k < PLEN; k++) pat[k] = 64'd1000 + 64'(k);
        run_case("clean R2 R3 R4", 1'b0);
        check(stamp == 64'd1001, "R2 stamp is sample after acceptance", stamp, 64'd1001);
    endtask

    task automatic t_equal;
        pat[0] = 64'd50;
        for (int k = 1; k < PLEN; k++) pat[k] = 64'd49 + 64'(k);
        run_case("equal-leading R5", 1'b0);
        pat[0] = 64'd7; pat[1] = 64'd8; pat[2] = 64'd8;
        for (int k = 3; k < PLEN; k++) pat[k] = 64'd6 + 64'(k);
        run_case("equal-middle R5", 1'b0);
    endtask

    task automatic t_glitch;
        pat[0] = 64'd2046; pat[1] = 64'd2047; pat[2] = 64'd1;
        for (int k = 3; k < PLEN; k++) pat[k] = 64'd2046 + 64'(k);
        run_case("backward R6", 1'b0);
        pat[0] = 64'd2046; pat[1] = 64'd4095;
        for (int k = 2; k < PLEN; k++) pat[k] = 64'd2046 + 64'(k);
        run_case("forward R6", 1'b0);
    endtask

    task automatic t_wrap;
        pat[0] = '1 - 64'd1; pat[1] = '1;
        for (int k = 2; k < PLEN; k++) pat[k] = 64'(k - 2);
        run_case("wraparound R7", 1'b0);
        for (int k = 0; k < PLEN; k++) pat[k] = 64'h7FFF_FFFF_FFFF_FFFE + 64'(k);
        run_case("unsigned top bit R7", 1'b0);
    endtask

    task automatic t_giveup;
        for (int k = 0; k < PLEN; k++) pat[k] = 64'd7;
        run_case("stuck R8", 1'b0);
        for (int k = 0; k < PLEN; k++) pat[k] = 64'd100 - 64'(k);
        run_case("falling R8", 1'b0);
        check(stamp == 64'd84, "R8 last middle sample", stamp, 64'd84);
    endtask

    task automatic t_busy_hold;
        for (int k = 0; k < PLEN; k++) pat[k] = 64'd300 + 64'(2 * k);
        run_case("held req R9", 1'b1);
    endtask

    task automatic t_mid_reset;
        @(negedge clk);
        req = 1'b1; cnt_raw = 64'd5;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; cnt_raw = 64'd6;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(rdy == 1'b1 && vld == 1'b0 && err == 1'b0, "R1 reset aborts request",
              64'({rdy, vld, err}), 64'b100);
        repeat (4) begin
            @(posedge clk);
            @(negedge clk);
            check(vld == 1'b0, "R1 no stale result after reset", 64'(vld), 64'd0);
        end
        for (int k = 0; k < PLEN; k++) pat[k] = 64'd9000 + 64'(k);
        run_case("after reset R1", 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_clean();
        t_equal();
        t_glitch();
        t_wrap();
        t_giveup();
        t_busy_hold();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule